// File: doc/BRIEF.md
# Double-Buffered Digital Crosspoint

This block is an N-by-N single-bit crosspoint: every output follows at most one input, while a single input may feed any number of outputs at the same time. The outputs are flow-through. Each output is driven combinationally from the input that its active selector names.

Connections are not programmed straight into the active selectors. A write port places a connect or disconnect for one output into a pending bank. A global update strobe (active low) then copies the whole pending bank into the active bank on one clock edge, so every output changes together. A clear operation empties the pending bank.

A broadcast override sends one chosen input to every output. It leaves both banks as they are. The next update ends the override and loads the active bank from the pending one. If nothing was written while broadcast was active, this restores the pattern that was in place before it. A readback port returns the selection that is currently in effect for any one output.

Top module: `xbar_dbuf`

## Requirements
- R1: After synchronous reset, every output is unconnected: it drives 0, readback returns valid 0 and index 0, and broadcast is off.
- R2: A write (`wr_conn`=1 connect, 0 disconnect) changes only the pending bank. Outputs and readback keep their values until an update occurs.
- R3: While `upd_n` is low at a clock edge, the active bank takes the pending bank as it stood before that edge. All outputs take their new sources together.
- R4: One input may be connected to several outputs at once, and all of them carry that input's value.
- R5: Writing a connect for an output that already has a source replaces the old source in that single write. No separate disconnect is needed.
- R6: A disconnect write marks that output's pending entry as unconnected. After an update the output drives 0.
- R7: `clr_en` marks every pending entry as unconnected. When `clr_en` and a write occur in the same cycle, the clear wins.
- R8: `bcast_en` with `upd_n` high makes every output follow `bcast_src` from the next edge on. Both banks are left unchanged.
- R9: An update while broadcast is active ends broadcast and loads the active bank from the pending bank. If no writes were made meanwhile, this restores the earlier pattern.
- R10: A write whose output index is N or more, a connect whose input index is N or more, and a broadcast whose source is N or more are all ignored.
- R11: An output with no active source drives constant 0.
- R12: An output whose selection does not change keeps following its input in every cycle, including during updates and broadcast changes that touch other outputs.
- R13: Readback for `rd_dst` < N returns the effective selection, including any broadcast override. For `rd_dst` ≥ N it returns valid 0 and index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write one pending entry |
| wr_dst | input | 7 | Output index of the write |
| wr_src | input | 7 | Input index of the write |
| wr_conn | input | 1 | 1 = connect, 0 = disconnect |
| clr_en | input | 1 | Clear the whole pending bank |
| upd_n | input | 1 | Global update strobe, active low |
| bcast_en | input | 1 | Enter or retarget broadcast |
| bcast_src | input | 7 | Broadcast input index |
| din | input | N_PORTS | Input data bits |
| dout | output | N_PORTS | Output data bits |
| rd_dst | input | 7 | Output index to read back |
| rd_vld | output | 1 | Effective selection is connected |
| rd_src | output | 7 | Effective input index |

## Verification
The hardest state to reach is a broadcast during which the pending bank has drifted away from the active bank, followed by an update that must pick up the drifted pending entries rather than the pre-broadcast ones. The bench reaches it in three steps. It programs and commits a pattern, enters broadcast, and then writes new pending entries while broadcast is active. Only after that does it pulse the update. A long random phase then mixes writes, clears, updates and broadcasts at varied rates, with fresh input data on every cycle. A reference model is compared against all outputs and the readback port on every clock.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
    localparam int XB_MAX_PORTS = 128;
    localparam int XB_IDX_W     = $clog2(XB_MAX_PORTS);
    localparam int XB_DEF_PORTS = 80;

    typedef logic [XB_IDX_W-1:0] xb_idx_t;

    typedef struct packed {
        logic    vld;
        xb_idx_t src;
    } xb_sel_t;

    function automatic logic idx_ok(input xb_idx_t idx, input int n);
        return int'(idx) < n;
    endfunction
endpackage

// File: rtl/xbar_shadow.sv
module xbar_shadow
    import xbar_pkg::*;
#(
    parameter int N_PORTS = XB_DEF_PORTS
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  xb_idx_t               wr_dst,
    input  xb_idx_t               wr_src,
    input  logic                  wr_conn,
    input  logic                  clr_en,
    output xb_sel_t [N_PORTS-1:0] pend_o
);
    xb_sel_t [N_PORTS-1:0] pend_q;
    logic    [N_PORTS-1:0] pend_vld;
    logic                  wr_ok;

    assign wr_ok = wr_en && idx_ok(wr_dst, N_PORTS)
                   && (!wr_conn || idx_ok(wr_src, N_PORTS));

    always_ff @(posedge clk) begin
        if (rst || clr_en) begin
            pend_q <= '0;
        end else if (wr_ok) begin
            for (int o = 0; o < N_PORTS; o++) begin
                if (wr_dst == XB_IDX_W'(o)) begin
                    pend_q[o].vld <= wr_conn;
                    pend_q[o].src <= wr_conn ? wr_src : '0;
                end
            end
        end
    end

    for (genvar o = 0; o < N_PORTS; o++) begin : g_vld
        assign pend_vld[o] = pend_q[o].vld;
    end

    assign pend_o = pend_q;

    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        clr_en |=> (pend_vld == '0)); // R7
    AST_OOR_WR_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !clr_en && !idx_ok(wr_dst, N_PORTS)) |=> $stable(pend_q)); // R10
endmodule

// File: rtl/xbar_active.sv
module xbar_active
    import xbar_pkg::*;
#(
    parameter int N_PORTS = XB_DEF_PORTS
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  upd_n,
    input  logic                  bcast_en,
    input  xb_idx_t               bcast_src,
    input  xb_sel_t [N_PORTS-1:0] pend_i,
    output xb_sel_t [N_PORTS-1:0] eff_o
);
    xb_sel_t [N_PORTS-1:0] act_q;
    logic                  bc_q;
    xb_idx_t               bc_src_q;
    logic                  bc_ok;

    assign bc_ok = bcast_en && idx_ok(bcast_src, N_PORTS);

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q    <= '0;
            bc_q     <= 1'b0;
            bc_src_q <= '0;
        end else if (!upd_n) begin
            act_q <= pend_i;
            bc_q  <= 1'b0;
        end else if (bc_ok) begin
            bc_q     <= 1'b1;
            bc_src_q <= bcast_src;
        end
    end

    for (genvar o = 0; o < N_PORTS; o++) begin : g_eff
        assign eff_o[o] = bc_q ? '{vld: 1'b1, src: bc_src_q} : act_q[o];
    end

    AST_UPD_COPIES: assert property (@(posedge clk) disable iff (rst)
        !upd_n |=> (act_q == $past(pend_i)) && !bc_q); // R3
    AST_ACT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        upd_n |=> $stable(act_q)); // R2
    AST_BC_ENTER: assert property (@(posedge clk) disable iff (rst)
        (upd_n && bc_ok) |=> bc_q && (bc_src_q == $past(bcast_src))); // R8
    AST_BC_OOR_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (upd_n && bcast_en && !bc_ok) |=> $stable(bc_q) && $stable(bc_src_q)); // R10
endmodule

// File: rtl/xbar_mux.sv
module xbar_mux
    import xbar_pkg::*;
#(
    parameter int N_PORTS = XB_DEF_PORTS
) (
    input  logic [N_PORTS-1:0]    din,
    input  xb_sel_t [N_PORTS-1:0] eff_i,
    output logic [N_PORTS-1:0]    dout
);
    for (genvar o = 0; o < N_PORTS; o++) begin : g_out
        always_comb begin
            dout[o] = 1'b0;
            for (int i = 0; i < N_PORTS; i++) begin
                if (eff_i[o].vld && eff_i[o].src == XB_IDX_W'(i)) dout[o] = din[i];
            end
        end
    end
endmodule

// File: rtl/xbar_dbuf.sv
module xbar_dbuf
    import xbar_pkg::*;
#(
    parameter int N_PORTS = XB_DEF_PORTS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [XB_IDX_W-1:0] wr_dst,
    input  logic [XB_IDX_W-1:0] wr_src,
    input  logic                wr_conn,
    input  logic                clr_en,
    input  logic                upd_n,
    input  logic                bcast_en,
    input  logic [XB_IDX_W-1:0] bcast_src,
    input  logic [N_PORTS-1:0]  din,
    output logic [N_PORTS-1:0]  dout,
    input  logic [XB_IDX_W-1:0] rd_dst,
    output logic                rd_vld,
    output logic [XB_IDX_W-1:0] rd_src
);
    xb_sel_t [N_PORTS-1:0] pend;
    xb_sel_t [N_PORTS-1:0] eff;

    xbar_shadow #(.N_PORTS(N_PORTS)) u_shadow (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_dst(wr_dst), .wr_src(wr_src),
        .wr_conn(wr_conn), .clr_en(clr_en), .pend_o(pend)
    );

    xbar_active #(.N_PORTS(N_PORTS)) u_active (
        .clk(clk), .rst(rst), .upd_n(upd_n), .bcast_en(bcast_en),
        .bcast_src(bcast_src), .pend_i(pend), .eff_o(eff)
    );

    xbar_mux #(.N_PORTS(N_PORTS)) u_mux (
        .din(din), .eff_i(eff), .dout(dout)
    );

    always_comb begin
        rd_vld = 1'b0;
        rd_src = '0;
        for (int o = 0; o < N_PORTS; o++) begin
            if (rd_dst == XB_IDX_W'(o)) begin
                rd_vld = eff[o].vld;
                rd_src = eff[o].src;
            end
        end
    end

    AST_RST_IDLE: assert property (@(posedge clk)
        rst |=> (dout == '0) && !rd_vld); // R1
endmodule

// File: tb/test_xbar_dbuf.sv
module test_xbar_dbuf;
    localparam int N   = 80;
    localparam int IW  = 7;
    localparam time CLK_PERIOD = 10ns;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 0, wr_conn = 0, clr_en = 0, upd_n = 1, bcast_en = 0;
    logic [IW-1:0] wr_dst = '0, wr_src = '0, bcast_src = '0, rd_dst = '0;
    logic [N-1:0]  din = '0;
    logic [N-1:0]  dout;
    logic          rd_vld;
    logic [IW-1:0] rd_src;

    int pend_m[N];
    int act_m[N];
    int bc_m = 0;
    int bc_src_m = 0;
    int n_chk = 0, n_fail = 0;
    bit comparing = 0, done = 0;
    string tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    xbar_dbuf #(.N_PORTS(N)) i_xbar_dbuf (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_dst(wr_dst), .wr_src(wr_src),
        .wr_conn(wr_conn), .clr_en(clr_en), .upd_n(upd_n), .bcast_en(bcast_en),
        .bcast_src(bcast_src), .din(din), .dout(dout), .rd_dst(rd_dst),
        .rd_vld(rd_vld), .rd_src(rd_src)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int eff_of(int o);
        return bc_m ? bc_src_m : act_m[o];
    endfunction

    function automatic logic [N-1:0] exp_dout();
        logic [N-1:0] v = '0;
        for (int o = 0; o < N; o++) if (eff_of(o) >= 0) v[o] = din[eff_of(o)];
        return v;
    endfunction

    initial for (int o = 0; o < N; o++) begin pend_m[o] = -1; act_m[o] = -1; end

    // reference model, advanced at each clock edge from the driven inputs
    always @(posedge clk) begin
        if (rst) begin
            for (int o = 0; o < N; o++) begin pend_m[o] = -1; act_m[o] = -1; end
            bc_m = 0;
        end else begin
            if (!upd_n) begin
                for (int o = 0; o < N; o++) act_m[o] = pend_m[o];
                bc_m = 0;
            end else if (bcast_en && int'(bcast_src) < N) begin
                bc_m = 1; bc_src_m = int'(bcast_src);
            end
            if (clr_en) begin
                for (int o = 0; o < N; o++) pend_m[o] = -1;
            end else if (wr_en && int'(wr_dst) < N && (!wr_conn || int'(wr_src) < N)) begin
                pend_m[wr_dst] = wr_conn ? int'(wr_src) : -1;
            end
        end
    end

    // compare every cycle away from the active edge
    always @(negedge clk) begin
        if (comparing && !done) begin
            logic [N-1:0] e;
            int ev;
            e = exp_dout();
            chk(dout === e, tag, "dout", dout, e);
            ev = (int'(rd_dst) < N) ? eff_of(int'(rd_dst)) : -1;
            chk((rd_vld === (ev >= 0)) && (rd_src === ((ev >= 0) ? IW'(ev) : '0)),
                "R13", "readback", N'({rd_vld, rd_src}),
                N'({ev >= 0, (ev >= 0) ? IW'(ev) : IW'(0)}));
        end
    end

    task automatic cyc();
        @(posedge clk); #1;
        wr_en = 0; clr_en = 0; upd_n = 1; bcast_en = 0;
        for (int b = 0; b < N; b++) din[b] = 1'($urandom);
    endtask

    task automatic wr(input int o, input int i, input bit c);
        wr_en = 1; wr_dst = IW'(o); wr_src = IW'(i); wr_conn = c; cyc();
    endtask

    task automatic upd();
        upd_n = 0; cyc();
    endtask

    task automatic rd_expect(input int o, input bit v, input int s, input string req);
        rd_dst = IW'(o); #1;
        chk(rd_vld === v && rd_src === IW'(s), req, "rd", N'({rd_vld, rd_src}), N'({v, IW'(s)}));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) cyc();
        rst = 0;
        cyc();
        // R1: reset state
        chk(dout === '0, "R1", "dout after reset", dout, '0);
        rd_expect(5, 0, 0, "R1");
        comparing = 1;

        tag = "R2";
        wr(3, 5, 1); wr(10, 5, 1); wr(79, 5, 1);
        chk(dout === '0, "R2", "dout before update", dout, '0);
        rd_expect(3, 0, 0, "R2");
        tag = "R3"; upd();
        rd_expect(10, 1, 5, "R3");
        tag = "R4"; din = '0; din[5] = 1; #1;
        chk(dout[3] && dout[10] && dout[79], "R4", "fanout", dout, dout | (N'(1) << 3));
        cyc(); cyc();

        tag = "R5"; wr(3, 7, 1); upd();
        rd_expect(3, 1, 7, "R5");
        tag = "R6"; wr(10, 0, 0); upd();
        rd_expect(10, 0, 0, "R6");
        tag = "R11"; din = '1; #1;
        chk(dout[10] === 1'b0, "R11", "unconnected output", N'(dout[10]), '0);
        cyc();

        tag = "R10";
        wr(80, 1, 1); wr(2, 90, 1); wr(127, 4, 1);
        bcast_en = 1; bcast_src = IW'(100); cyc();
        upd();
        rd_expect(2, 0, 0, "R10");
        rd_expect(79, 1, 5, "R10");

        tag = "R8";
        bcast_en = 1; bcast_src = IW'(12); cyc();
        rd_expect(40, 1, 12, "R8");
        wr(40, 33, 1);
        bcast_en = 1; bcast_src = IW'(0); cyc();
        rd_expect(3, 1, 0, "R8");
        tag = "R9"; upd();
        rd_expect(3, 1, 7, "R9");
        rd_expect(40, 1, 33, "R9");
        rd_expect(11, 0, 0, "R9");

        tag = "R7";
        clr_en = 1; wr_en = 1; wr_dst = 6; wr_src = 6; wr_conn = 1; cyc();
        rd_expect(3, 1, 7, "R7");
        upd();
        rd_expect(3, 0, 0, "R7");
        rd_expect(6, 0, 0, "R7");
        chk(dout === '0, "R7", "dout after cleared update", dout, '0);
        rd_expect(90, 0, 0, "R13");

        tag = "R12";
        for (int k = 0; k < 3000; k++) begin
            int r = int'($urandom % 100);
            rd_dst = IW'($urandom % 90);
            if (r < 50) begin
                wr_en = 1; wr_dst = IW'($urandom % 84); wr_src = IW'($urandom % 84);
                wr_conn = ($urandom % 4) != 0;
            end
            if (r >= 50 && r < 58) upd_n = 0;
            if (r >= 58 && r < 62) begin bcast_en = 1; bcast_src = IW'($urandom % 84); end
            if (r == 62) clr_en = 1;
            cyc();
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule